// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the two timing strobes a UART needs from one source clock. The first stage removes a controlled share of clock cycles, which lowers the rate to clock / (1 + M/256) for an 8-bit M. The second stage is an integer divider by B + 1. The third stage is an oversample divider by O + 1, with O limited to the range 4..15. The oversample strobe paces the receiver's sampling logic. The bit strobe marks each bit period. Both are single-cycle clock enables in the source clock domain, so nothing downstream has to cross to a derived clock.

The four divider fields arrive as register values: M, a denominator code, B and O. They are captured together on a write strobe. That same strobe restarts every stage, so the first strobes after a reconfiguration come exactly one full period later. Software chooses M and B to approach the target rate. The resulting bit rate is clock / (1 + M/256) / (B + 1) / (O + 1).

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low both strobes are 0. Reset loads M = 0, denominator code 0xFF, B = 0 and O = 15. With these defaults, the oversample strobe is high on every edge from the first edge after reset release, and the bit strobe is high on every 16th edge.
- R2: With denominator code 0xFF, the fractional stage gives 256 enables in every 256 + M clocks. Counting edges from the restart edge (edge 0), enable k (k = 1, 2, ...) lands at edge k + floor((k-1)·M/256).
- R3: Any denominator code other than 0xFF bypasses the fractional stage, and M has no effect: one enable per clock.
- R4: Oversample strobe n is driven by fractional enable n·(B+1), so it appears at the edge that R2 gives for k = n·(B+1).
- R5: Bit strobe n is driven by fractional enable n·(B+1)·(O+1), and every bit strobe coincides with an oversample strobe.
- R6: An O value below 4 is used as 4, which gives a minimum oversample ratio of 5.
- R7: On an edge where `cfg_wr` is high, all four fields are captured and every stage and both strobes are cleared. Neither strobe is high after that edge, and the timing of R2, R4 and R5 counts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Capture the divider fields and restart all stages |
| cfg_mult | input | 8 | Fractional numerator M |
| cfg_den | input | 8 | Denominator code; only 0xFF enables the fractional stage |
| cfg_brg | input | BRG_W | Integer divider value B (divide by B+1) |
| cfg_osr | input | OSR_W | Oversample value O (divide by O+1, at least 4) |
| os_tick | output | 1 | Oversample clock-enable strobe |
| bit_tick | output | 1 | Bit-period clock-enable strobe |

## Verification
Every strobe is due at an exact edge. For strobe n, let k be n·(B+1) (oversample) or n·(B+1)·(O+1) (bit); the strobe is due k + floor((k-1)·M/256) edges after the restart edge, with M taken as 0 when the fractional stage is bypassed. One output register lies between the enable and the pin, and the edge count absorbs it. After each write, the driver computes these edge numbers from the requirements and queues them. A monitor counts edges from the restart, samples on the falling clock edge, and matches each strobe it sees against the head of its queue; a strobe with no entry or at the wrong edge is a miscompare. The edge right after a write is checked for silence.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   localparam int FRAC_W        = 8;
   localparam int FRAC_DEN_CODE = (1 << FRAC_W) - 1;
   typedef logic [FRAC_W-1:0] frac_t;
endpackage

// File: rtl/fbg_frac_stage.sv
module fbg_frac_stage #(
   parameter int W      = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] mult_i,
   input  logic [W-1:0] den_i,
   output logic         en_o
);
   if (ENABLE) begin : g_acc
      logic [W-1:0] acc_q;
      logic         swallow_q;
      logic         bypass;
      logic [W:0]   sum;

      assign bypass = (den_i != {W{1'b1}});
      assign sum    = {1'b0, acc_q} + {1'b0, mult_i};

      // each emitted enable adds M; a carry swallows the following cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q     <= '0;
            swallow_q <= 1'b0;
         end else if (clr_i || bypass) begin
            acc_q     <= '0;
            swallow_q <= 1'b0;
         end else if (swallow_q) begin
            swallow_q <= 1'b0;
         end else begin
            acc_q     <= sum[W-1:0];
            swallow_q <= sum[W];
         end
      end

      assign en_o = !clr_i && (bypass || !swallow_q);
   end else begin : g_plain
      logic unused_cfg;
      assign unused_cfg = ^{mult_i, den_i, clk, rst_n};
      assign en_o       = !clr_i;
   end
endmodule

// File: rtl/fbg_int_div.sv
module fbg_int_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic [W-1:0] limit_i,
   output logic         en_o
);
   logic [W-1:0] cnt_q;
   logic         hit;

   assign hit  = (cnt_q == limit_i);
   assign en_o = en_i && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import fbg_pkg::*;
#(
   parameter int BRG_W    = 16,
   parameter int OSR_W    = 4,
   parameter int OSR_MIN  = 4,
   parameter int OSR_RST  = 15,
   parameter bit HAS_FRAC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [FRAC_W-1:0] cfg_mult,
   input  logic [FRAC_W-1:0] cfg_den,
   input  logic [BRG_W-1:0] cfg_brg,
   input  logic [OSR_W-1:0] cfg_osr,
   output logic             os_tick,
   output logic             bit_tick
);
   localparam logic [OSR_W-1:0] OSR_FLOOR = OSR_W'(OSR_MIN);
   localparam logic [OSR_W-1:0] OSR_BOOT  = OSR_W'(OSR_RST);
   localparam frac_t            DEN_BOOT  = frac_t'(FRAC_DEN_CODE);

   // elaboration-time parameter checks
   if (BRG_W < 1) begin : g_bad_brg_w
      initial $fatal(1, "BRG_W must be at least 1");
   end
   if (OSR_MIN < 1 || OSR_MIN >= (1 << OSR_W)) begin : g_bad_osr_min
      initial $fatal(1, "OSR_MIN out of range for OSR_W");
   end
   if (OSR_RST < OSR_MIN || OSR_RST >= (1 << OSR_W)) begin : g_bad_osr_rst
      initial $fatal(1, "OSR_RST out of range");
   end

   frac_t            mult_q;
   frac_t            den_q;
   logic [BRG_W-1:0] brg_q;
   logic [OSR_W-1:0] osr_q;
   logic [OSR_W-1:0] osr_in_eff;
   logic             frac_en;
   logic             brg_en;
   logic             osr_en;
   logic             os_tick_q;
   logic             bit_tick_q;

   assign osr_in_eff = (cfg_osr < OSR_FLOOR) ? OSR_FLOOR : cfg_osr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mult_q <= '0;
         den_q  <= DEN_BOOT;
         brg_q  <= '0;
         osr_q  <= OSR_BOOT;
      end else if (cfg_wr) begin
         mult_q <= cfg_mult;
         den_q  <= cfg_den;
         brg_q  <= cfg_brg;
         osr_q  <= osr_in_eff;
      end
   end

   fbg_frac_stage #(
      .W      (FRAC_W),
      .ENABLE (HAS_FRAC)
   ) u_frac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cfg_wr),
      .mult_i (mult_q),
      .den_i  (den_q),
      .en_o   (frac_en)
   );

   fbg_int_div #(
      .W (BRG_W)
   ) u_brg (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (cfg_wr),
      .en_i    (frac_en),
      .limit_i (brg_q),
      .en_o    (brg_en)
   );

   fbg_int_div #(
      .W (OSR_W)
   ) u_osr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (cfg_wr),
      .en_i    (brg_en),
      .limit_i (osr_q),
      .en_o    (osr_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         os_tick_q  <= 1'b0;
         bit_tick_q <= 1'b0;
      end else if (cfg_wr) begin
         os_tick_q  <= 1'b0;
         bit_tick_q <= 1'b0;
      end else begin
         os_tick_q  <= brg_en;
         bit_tick_q <= osr_en;
      end
   end

   assign os_tick  = os_tick_q;
   assign bit_tick = bit_tick_q;
endmodule

// File: rtl/fbg_chk.sv
module fbg_chk #(
   parameter int OSR_MIN = 4,
   parameter int FRAC_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic              os_tick,
   input logic              bit_tick,
   input logic              frac_en,
   input logic [FRAC_W-1:0] den_q
);
   logic [31:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (cfg_wr) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (bit_tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 32'hFFFF_FFFF) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R5
   bit_on_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick);

   // R7
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!os_tick && !bit_tick));

   // R3
   den_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && den_q != {FRAC_W{1'b1}}) |-> frac_en);

   // R2
   single_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frac_en && !cfg_wr) |=> (frac_en || cfg_wr));

   // R6
   min_bit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && seen_q && !cfg_wr) |-> (gap_q >= OSR_MIN));
endmodule

bind frac_baud_gen fbg_chk #(
   .OSR_MIN (OSR_MIN),
   .FRAC_W  (fbg_pkg::FRAC_W)
) u_fbg_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_wr   (cfg_wr),
   .os_tick  (os_tick),
   .bit_tick (bit_tick),
   .frac_en  (frac_en),
   .den_q    (den_q)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [7:0]  cfg_mult;
   logic [7:0]  cfg_den;
   logic [15:0] cfg_brg;
   logic [3:0]  cfg_osr;
   logic        os_tick;
   logic        bit_tick;

   int    since;
   int    exp_os_q[$];
   int    exp_bit_q[$];
   bit    armed = 1'b0;
   string cur_tag = "R1";
   int    n_chk = 0;
   int    n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_baud_gen i_frac_baud_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_mult (cfg_mult),
      .cfg_den  (cfg_den),
      .cfg_brg  (cfg_brg),
      .cfg_osr  (cfg_osr),
      .os_tick  (os_tick),
      .bit_tick (bit_tick)
   );

   // edges since the restart edge (reset release counts as edge 0)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      since <= 0;
      else if (cfg_wr) since <= 0;
      else             since <= since + 1;
   end

   task automatic note_fail(string tag, string what, int act, int exp);
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      n_fail++;
   endtask

   function automatic int due_edge(int k, int m);
      return k + ((k - 1) * m) / 256;
   endfunction

   task automatic load_expect(int m, int b, int o, int nbits);
      for (int n = 1; n <= nbits * (o + 1); n++) exp_os_q.push_back(due_edge(n * (b + 1), m));
      for (int n = 1; n <= nbits; n++) exp_bit_q.push_back(due_edge(n * (b + 1) * (o + 1), m));
   endtask

   task automatic drain();
      int guard = 0;
      while ((exp_os_q.size() > 0 || exp_bit_q.size() > 0) && guard < 20000) begin
         @(posedge clk);
         guard++;
      end
      @(negedge clk);
      armed = 1'b0;
      foreach (exp_os_q[i]) begin
         n_chk++;
         note_fail(cur_tag, "missing os_tick at edge", -1, exp_os_q[i]);
      end
      foreach (exp_bit_q[i]) begin
         n_chk++;
         note_fail(cur_tag, "missing bit_tick at edge", -1, exp_bit_q[i]);
      end
      exp_os_q.delete();
      exp_bit_q.delete();
   endtask

   task automatic run_cfg(string tag, int m, int d, int b, int o, int nbits, int eff_m, int eff_o);
      @(posedge clk);
      #1;
      cfg_wr   = 1'b1;
      cfg_mult = 8'(m);
      cfg_den  = 8'(d);
      cfg_brg  = 16'(b);
      cfg_osr  = 4'(o);
      @(posedge clk);
      #1;
      cfg_wr  = 1'b0;
      cur_tag = tag;
      load_expect(eff_m, b, eff_o, nbits);
      armed = 1'b1;
      drain();
   endtask

   // monitor: pops the expected edge number for every strobe it sees
   always @(negedge clk) begin : mon
      int e;
      if (rst_n && armed) begin
         if (since == 0) begin
            n_chk++;
            if (os_tick || bit_tick)
               note_fail("R7", "strobe on restart edge", {os_tick, bit_tick}, 0);
         end
         if (os_tick) begin
            n_chk++;
            if (exp_os_q.size() == 0) note_fail(cur_tag, "unexpected os_tick at edge", since, -1);
            else begin
               e = exp_os_q.pop_front();
               if (e != since) note_fail(cur_tag, "os_tick edge", since, e);
            end
         end
         if (bit_tick) begin
            n_chk++;
            if (exp_bit_q.size() == 0) note_fail(cur_tag, "unexpected bit_tick at edge", since, -1);
            else begin
               e = exp_bit_q.pop_front();
               if (e != since) note_fail(cur_tag, "bit_tick edge", since, e);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : driver
      rst_n    = 1'b0;
      cfg_wr   = 1'b0;
      cfg_mult = 8'd99;
      cfg_den  = 8'd0;
      cfg_brg  = 16'd7;
      cfg_osr  = 4'd9;
      repeat (3) @(negedge clk);
      // R1: strobes low during reset
      n_chk++;
      if (os_tick || bit_tick) note_fail("R1", "strobes in reset", {os_tick, bit_tick}, 0);
      // R1: defaults M=0, den 0xFF, B=0, O=15 after release
      cur_tag = "R1";
      load_expect(0, 0, 15, 3);
      armed = 1'b1;
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      drain();

      run_cfg("R4", 0,   255, 0, 15, 3, 0,   15);
      run_cfg("R2", 64,  255, 0, 4,  6, 64,  4);
      run_cfg("R2", 255, 255, 2, 7,  3, 255, 7);
      run_cfg("R3", 200, 127, 1, 5,  4, 0,   5);
      run_cfg("R6", 10,  255, 1, 1,  5, 10,  4);
      run_cfg("R6", 0,   255, 0, 0,  4, 0,   4);
      run_cfg("R5", 128, 255, 5, 15, 2, 128, 15);
      run_cfg("R7", 37,  255, 3, 9,  2, 37,  9);
      run_cfg("R4", 1,   255, 9, 4,  2, 1,   4);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule